// File: doc/BRIEF.md
# DRAM Retention Characterization Engine

This block is a test sequencer that measures how long each DRAM page holds its data without refresh. After a start request it switches refresh off and walks the pages from address 0 upward. For every page it runs a set of trials: half of them fill the page with ones and half with zeros. Each trial writes the fill to the page, waits a trial interval T counted in milliseconds, reads the page back and compares every bit with the fill. When the readback is clean, T grows by a programmed step and the write, wait and read repeat. At the first corrupted readback the trial result is the last interval that still passed.

The lowest trial result of a page, with a flag that marks a page that never failed, goes into an internal result RAM indexed by page number. When the last page is stored the engine switches refresh back on and pulses done. The memory sits behind a one-command-per-cycle interface: write page, read page, refresh off and refresh on. A read answers with one data word on a response strobe a cycle or more later. The millisecond wait is derived from the clock through a cycles-per-millisecond parameter.

States: IDLE (waits for start), REF_OFF (issues refresh-off), WRITE (issues the page write and loads the timer), WAIT (runs until the timer expires), READ (issues the page read), CHECK (waits for the response and grades it), TRIAL_END (folds the trial result into the page minimum), PAGE_END (stores the page result), REF_ON (issues refresh-on and pulses done). Transitions: IDLE→REF_OFF on start; REF_OFF→WRITE; WRITE→WAIT; WAIT→READ on expiry; READ→CHECK; CHECK→WRITE on a clean readback with room to grow; CHECK→TRIAL_END on a corrupted readback or a saturated interval; TRIAL_END→WRITE for a further trial, TRIAL_END→PAGE_END after the last trial; PAGE_END→WRITE for the next page, PAGE_END→REF_ON after the last page; REF_ON→IDLE.

Top module: `retention_probe`

## Requirements
- R1: After reset busy, done and cmd_valid are 0.
- R2: A start pulse in IDLE captures cfg_t_init, cfg_t_step and cfg_t_max, raises busy in the next cycle, and the first command issued is refresh-off (cmd_op 2).
- R3: No page write (cmd_op 0) or page read (cmd_op 1) is issued unless refresh-off has been issued since the last refresh-on; exactly one refresh-off and one refresh-on (cmd_op 3) are issued per run.
- R4: The read of a trial step follows its write by exactly T*CYC_PER_MS+1 cycles, and a readback counts as clean only when all DW bits equal the fill value.
- R5: Each trial starts with T equal to the initial interval; after a clean readback T grows by the step and the page is written again; on the first corrupted readback the trial result is T minus the step, or 0 if T is below the step.
- R6: If a clean readback leaves T plus the step above the maximum interval, the trial ends with result equal to the maximum and is marked saturated.
- R7: Per page the first TRIALS_PER_FILL trials write fill 1 (all ones) and the next TRIALS_PER_FILL write fill 0 (all zeros); no ones write follows a zeros write on the same page.
- R8: The stored page time is the minimum of all 2*TRIALS_PER_FILL trial results, and the stored saturation flag is 1 only if every trial of the page saturated.
- R9: Pages are measured in ascending order 0..PAGES-1, and res_time/res_sat show the stored result of page res_addr combinationally.
- R10: done is high for exactly one cycle, in the cycle that issues refresh-on, and busy is 0 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a characterization run (taken in IDLE only) |
| cfg_t_init | input | TW | Initial trial interval, ms |
| cfg_t_step | input | TW | Interval increment, ms |
| cfg_t_max | input | TW | Largest interval tried, ms |
| cmd_valid | output | 1 | Memory command present this cycle |
| cmd_op | output | 2 | 0 write page, 1 read page, 2 refresh off, 3 refresh on |
| cmd_page | output | PW | Page addressed by the command |
| cmd_fill | output | 1 | Fill bit replicated across the page on a write |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | DW | Read response data |
| res_addr | input | PW | Result RAM read address |
| res_time | output | TW | Stored retention of page res_addr, ms |
| res_sat | output | 1 | Page res_addr never failed up to the maximum |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A state register or counter that drifts shows up at the command port within one trial step: a wrong interval moves the read away from write plus T*CYC_PER_MS+1 cycles, and a wrong fill or page index appears on the very next write. Errors in the result path (step subtraction, saturation, minimum folding) only surface when the result RAM is read after done, so the bench compares every page against values it computes from its own memory model. The memory model is built with one deliberately weaker trial per polarity on most pages, so a minimum taken over too few trials or only one polarity gives a wrong stored time.

// File: rtl/retprobe_pkg.sv
package retprobe_pkg;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_READ    = 2'd1,
        OP_REF_OFF = 2'd2,
        OP_REF_ON  = 2'd3
    } mem_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REF_OFF,
        S_WRITE,
        S_WAIT,
        S_READ,
        S_CHECK,
        S_TRIAL_END,
        S_PAGE_END,
        S_REF_ON
    } probe_state_e;

endpackage

// File: rtl/ms_wait_timer.sv
module ms_wait_timer #(
    parameter int TW         = 12,
    parameter int CYC_PER_MS = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] target_ms,
    output logic          expired
);
    localparam int SW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

    logic          run_q;
    logic [SW-1:0] sub_q;
    logic [TW:0]   ms_q;
    logic [TW-1:0] tgt_q;
    logic          ms_edge;

    assign ms_edge = (sub_q == SW'(CYC_PER_MS - 1));
    assign expired = run_q && ms_edge && ((ms_q + (TW+1)'(1)) >= {1'b0, tgt_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            sub_q <= '0;
            ms_q  <= '0;
            tgt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            sub_q <= '0;
            ms_q  <= '0;
            tgt_q <= target_ms;
        end else if (run_q) begin
            if (ms_edge) begin
                sub_q <= '0;
                ms_q  <= ms_q + (TW+1)'(1);
                if (expired) run_q <= 1'b0;
            end else begin
                sub_q <= sub_q + SW'(1);
            end
        end
    end

    // R4
    expired_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> !expired);

endmodule

// File: rtl/result_store.sv
module result_store #(
    parameter int PAGES = 8,
    parameter int TW    = 12
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(PAGES)-1:0] waddr,
    input  logic [TW-1:0]            wtime,
    input  logic                     wsat,
    input  logic [$clog2(PAGES)-1:0] raddr,
    output logic [TW-1:0]            rtime,
    output logic                     rsat
);
    logic [TW-1:0] time_mem [PAGES];
    logic          sat_mem  [PAGES];

    always_ff @(posedge clk) begin
        if (we) begin
            time_mem[waddr] <= wtime;
            sat_mem[waddr]  <= wsat;
        end
    end

    assign rtime = time_mem[raddr];
    assign rsat  = sat_mem[raddr];

endmodule

// File: rtl/retention_probe.sv
module retention_probe
    import retprobe_pkg::*;
#(
    parameter int PAGES           = 8,
    parameter int DW              = 16,
    parameter int TW              = 12,
    parameter int TRIALS_PER_FILL = 10,
    parameter int CYC_PER_MS      = 1000,
    localparam int PW             = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] cfg_t_init,
    input  logic [TW-1:0] cfg_t_step,
    input  logic [TW-1:0] cfg_t_max,
    output logic          cmd_valid,
    output logic [1:0]    cmd_op,
    output logic [PW-1:0] cmd_page,
    output logic          cmd_fill,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    input  logic [PW-1:0] res_addr,
    output logic [TW-1:0] res_time,
    output logic          res_sat,
    output logic          busy,
    output logic          done
);
    localparam int NTRIAL = 2 * TRIALS_PER_FILL;
    localparam int XW     = $clog2(NTRIAL);

    probe_state_e  state, state_n;
    logic [TW-1:0] init_q, step_q, max_q;
    logic [TW-1:0] cur_t, min_t, trial_res;
    logic          trial_sat, all_sat;
    logic [PW-1:0] page_idx;
    logic [XW-1:0] trial_idx;
    logic          fill, match, over, tmr_expired, tmr_load, ram_we;
    logic [TW:0]   t_next;
    logic          last_trial, last_page, ref_off_r;
    mem_op_e       op;

    assign fill       = (trial_idx < XW'(TRIALS_PER_FILL));
    assign match      = (rsp_data == {DW{fill}});
    assign t_next     = {1'b0, cur_t} + {1'b0, step_q};
    assign over       = (t_next > {1'b0, max_q});
    assign last_trial = (trial_idx == XW'(NTRIAL - 1));
    assign last_page  = (page_idx == PW'(PAGES - 1));

    ms_wait_timer #(.TW(TW), .CYC_PER_MS(CYC_PER_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .target_ms(cur_t), .expired(tmr_expired)
    );

    result_store #(.PAGES(PAGES), .TW(TW)) u_store (
        .clk(clk), .we(ram_we), .waddr(page_idx), .wtime(min_t), .wsat(all_sat),
        .raddr(res_addr), .rtime(res_time), .rsat(res_sat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:      if (start) state_n = S_REF_OFF;
            S_REF_OFF:   state_n = S_WRITE;
            S_WRITE:     state_n = S_WAIT;
            S_WAIT:      if (tmr_expired) state_n = S_READ;
            S_READ:      state_n = S_CHECK;
            S_CHECK:     if (rsp_valid) state_n = (match && !over) ? S_WRITE : S_TRIAL_END;
            S_TRIAL_END: state_n = last_trial ? S_PAGE_END : S_WRITE;
            S_PAGE_END:  state_n = last_page ? S_REF_ON : S_WRITE;
            S_REF_ON:    state_n = S_IDLE;
            default:     state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        op        = OP_WRITE;
        done      = 1'b0;
        tmr_load  = 1'b0;
        ram_we    = 1'b0;
        unique case (state)
            S_REF_OFF:  begin cmd_valid = 1'b1; op = OP_REF_OFF; end
            S_WRITE:    begin cmd_valid = 1'b1; op = OP_WRITE; tmr_load = 1'b1; end
            S_READ:     begin cmd_valid = 1'b1; op = OP_READ; end
            S_PAGE_END: ram_we = 1'b1;
            S_REF_ON:   begin cmd_valid = 1'b1; op = OP_REF_ON; done = 1'b1; end
            default:    ;
        endcase
    end

    assign cmd_op   = op;
    assign cmd_page = page_idx;
    assign cmd_fill = fill;
    assign busy     = (state != S_IDLE);

    // trial and page datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= '0; step_q <= '0; max_q <= '0;
            cur_t <= '0; min_t <= '1; trial_res <= '0;
            trial_sat <= 1'b0; all_sat <= 1'b1;
            page_idx <= '0; trial_idx <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    init_q    <= cfg_t_init;
                    step_q    <= cfg_t_step;
                    max_q     <= cfg_t_max;
                    cur_t     <= cfg_t_init;
                    min_t     <= '1;
                    all_sat   <= 1'b1;
                    page_idx  <= '0;
                    trial_idx <= '0;
                end
                S_CHECK: if (rsp_valid) begin
                    if (match) begin
                        if (over) begin
                            trial_res <= max_q;
                            trial_sat <= 1'b1;
                        end else begin
                            cur_t <= t_next[TW-1:0];
                        end
                    end else begin
                        trial_res <= (cur_t >= step_q) ? (cur_t - step_q) : '0;
                        trial_sat <= 1'b0;
                    end
                end
                S_TRIAL_END: begin
                    if (trial_res < min_t) min_t <= trial_res;
                    all_sat <= all_sat & trial_sat;
                    if (!last_trial) begin
                        trial_idx <= trial_idx + XW'(1);
                        cur_t     <= init_q;
                    end
                end
                S_PAGE_END: if (!last_page) begin
                    page_idx  <= page_idx + PW'(1);
                    trial_idx <= '0;
                    cur_t     <= init_q;
                    min_t     <= '1;
                    all_sat   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // refresh tracking for the guard below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_off_r <= 1'b0;
        else if (cmd_valid && op == OP_REF_OFF) ref_off_r <= 1'b1;
        else if (cmd_valid && op == OP_REF_ON)  ref_off_r <= 1'b0;
    end

    // R3
    refresh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_WRITE || op == OP_READ)) |-> ref_off_r);

    // R9
    page_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && $past(state) != S_IDLE) |-> (page_idx >= $past(page_idx)));

    // R8
    min_nonincr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRIAL_END) |=> (min_t <= $past(min_t)));

    // R6
    trial_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRIAL_END) |-> (trial_res <= max_q));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/retention_probe_test.sv
module retention_probe_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES = 8;
    localparam int DW    = 16;
    localparam int TW    = 12;
    localparam int TPF   = 10;
    localparam int CYC   = 2;
    localparam int PW    = $clog2(PAGES);
    localparam int LIMIT = 90000;

    logic clk = 0, rst_n = 0, start = 0;
    logic [TW-1:0] cfg_t_init = '0, cfg_t_step = '0, cfg_t_max = '0;
    logic cmd_valid, cmd_fill, busy, done, res_sat;
    logic [1:0] cmd_op;
    logic [PW-1:0] cmd_page;
    logic rsp_valid = 0;
    logic [DW-1:0] rsp_data = '0;
    logic [PW-1:0] res_addr = '0;
    logic [TW-1:0] res_time;

    retention_probe #(.PAGES(PAGES), .DW(DW), .TW(TW), .TRIALS_PER_FILL(TPF), .CYC_PER_MS(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_t_init(cfg_t_init), .cfg_t_step(cfg_t_step), .cfg_t_max(cfg_t_max),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_fill(cmd_fill),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .res_addr(res_addr), .res_time(res_time), .res_sat(res_sat),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit hung = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // test configuration and memory model state
    int t_init, t_step, t_max;
    int base [2][PAGES];
    int dip_at [2][PAGES];
    int dip_amt [2][PAGES];
    int fails [2][PAGES];
    longint wr_cyc [PAGES];
    int last_ms [PAGES];
    bit last_pass [PAGES];
    bit fill_stored [PAGES];
    bit seen0 [PAGES];
    int last_page, n_cmds, first_op, n_refoff, n_refon;
    bit ref_on;
    longint cyc = 0;

    task automatic model_reset();
        for (int p = 0; p < PAGES; p++) begin
            fails[0][p] = 0; fails[1][p] = 0;
            last_pass[p] = 0; last_ms[p] = 0; seen0[p] = 0;
        end
        last_page = 0; n_cmds = 0; first_op = -1; n_refoff = 0; n_refon = 0;
        ref_on = 1;
    endtask

    // behavioural memory with per-page, per-fill retention
    always @(posedge clk) begin
        cyc++;
        rsp_valid <= 1'b0;
        if (rst_n && cmd_valid) begin
            if (n_cmds == 0) first_op = int'(cmd_op);
            n_cmds++;
            case (cmd_op)
                2'd2: begin ref_on = 0; n_refoff++; end
                2'd3: begin ref_on = 1; n_refon++; end
                2'd0: begin
                    chk(!ref_on, "R3 write with refresh on", 1, 0);
                    chk(int'(cmd_page) >= last_page, "R9 page order", cmd_page, last_page);
                    last_page = int'(cmd_page);
                    if (cmd_fill == 1'b0) seen0[cmd_page] = 1;
                    else chk(!seen0[cmd_page], "R7 ones fill after zeros", 1, 0);
                    fill_stored[cmd_page] = cmd_fill;
                    wr_cyc[cmd_page] = cyc;
                end
                2'd1: begin
                    longint el;
                    int ms, exp_ms, r, f, p;
                    bit pass;
                    p  = int'(cmd_page);
                    f  = int'(fill_stored[p]);
                    chk(!ref_on, "R3 read with refresh on", 1, 0);
                    el = cyc - wr_cyc[p];
                    chk(((el - 1) % CYC) == 0, "R4 write-to-read spacing", el, el - ((el - 1) % CYC));
                    ms = int'((el - 1) / CYC);
                    exp_ms = (last_pass[p] && (last_ms[p] + t_step <= t_max)) ? last_ms[p] + t_step : t_init;
                    chk(ms == exp_ms, "R5 trial interval", ms, exp_ms);
                    r = base[f][p] - ((fails[f][p] == dip_at[f][p]) ? dip_amt[f][p] : 0);
                    if (r < 0) r = 0;
                    pass = (ms <= r);
                    if (pass) rsp_data <= {DW{fill_stored[p]}};
                    else begin
                        rsp_data <= {DW{fill_stored[p]}} ^ (DW'(1) << $urandom_range(0, DW-1));
                        fails[f][p]++;
                    end
                    last_pass[p] = pass;
                    last_ms[p] = ms;
                    rsp_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    function automatic void trial_calc(input int r, output int res, output bit sat);
        int t;
        t = t_init;
        sat = 0;
        if (t > r) begin
            res = (t >= t_step) ? t - t_step : 0;
            return;
        end
        forever begin
            if (t + t_step > t_max) begin res = t_max; sat = 1; return; end
            t += t_step;
            if (t > r) begin res = t - t_step; return; end
        end
    endfunction

    task automatic run(input int ti, input int ts, input int tm);
        int waited, done_cnt;
        t_init = ti; t_step = ts; t_max = tm;
        model_reset();
        @(negedge clk);
        cfg_t_init = TW'(ti); cfg_t_step = TW'(ts); cfg_t_max = TW'(tm);
        start = 1;
        @(negedge clk);
        start = 0;
        // config changed while busy must have no effect (captured at start)
        cfg_t_init = TW'(ti + 1); cfg_t_step = '0; cfg_t_max = '0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        waited = 0; done_cnt = 0;
        while (!done && waited < LIMIT) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            hung = 1;
            chk(0, "watchdog", waited, LIMIT);
            return;
        end
        chk(cmd_valid && cmd_op == 2'd3, "R10 done with refresh-on", cmd_op, 3);
        @(negedge clk);
        chk(!done && !busy, "R10 single done and busy low", {done, busy}, 0);
        chk(first_op == 2, "R2 first command refresh-off", first_op, 2);
        chk(n_refoff == 1 && n_refon == 1, "R3 one refresh-off and one refresh-on", n_refoff * 10 + n_refon, 11);
        chk(last_page == PAGES - 1, "R9 last page measured", last_page, PAGES - 1);
        for (int p = 0; p < PAGES; p++) begin
            int mn, res;
            bit all_sat, sat;
            mn = 32'h7fffffff; all_sat = 1;
            for (int f = 1; f >= 0; f--) begin
                int cnt;
                cnt = 0;
                for (int j = 0; j < TPF; j++) begin
                    int r;
                    r = base[f][p] - ((cnt == dip_at[f][p]) ? dip_amt[f][p] : 0);
                    if (r < 0) r = 0;
                    trial_calc(r, res, sat);
                    if (res < mn) mn = res;
                    all_sat &= sat;
                    if (!sat) cnt++;
                end
                chk(fails[f][p] == cnt, "R7 corrupted reads per fill", fails[f][p], cnt);
            end
            res_addr = PW'(p);
            #1;
            chk(int'(res_time) == mn, "R8 page minimum time", res_time, mn);
            chk(res_sat == all_sat, "R6 R8 saturation flag", res_sat, all_sat);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        #1;
        chk(!busy && !done && !cmd_valid, "R1 reset outputs", {busy, done, cmd_valid}, 0);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R1 idle after reset", {busy, done, cmd_valid}, 0);

        // run 1: random retentions, one weak trial per fill on most pages
        for (int p = 0; p < PAGES; p++)
            for (int f = 0; f < 2; f++) begin
                base[f][p]    = $urandom_range(3, 14);
                dip_at[f][p]  = $urandom_range(0, TPF - 1);
                dip_amt[f][p] = $urandom_range(1, 5);
            end
        base[1][0] = 0; dip_amt[1][0] = 0;          // immediate failure, clamp to 0 (R5)
        base[0][6] = 100; base[1][6] = 100;         // never fails: saturates (R6)
        dip_amt[0][6] = 0; dip_amt[1][6] = 0;
        base[0][3] = 40; dip_amt[0][3] = 0;         // one fill saturates, other does not (R8)
        run(2, 3, 30);

        // run 2: coarse steps, saturation likely for longer pages
        if (!hung) begin
            for (int p = 0; p < PAGES; p++)
                for (int f = 0; f < 2; f++) begin
                    base[f][p]    = $urandom_range(0, 20);
                    dip_at[f][p]  = $urandom_range(0, TPF - 1);
                    dip_amt[f][p] = $urandom_range(0, 8);
                end
            run(4, 4, 14);
        end

        // run 3: directed, step larger than start so first failure clamps to 0
        if (!hung) begin
            for (int p = 0; p < PAGES; p++)
                for (int f = 0; f < 2; f++) begin
                    base[f][p] = p; dip_at[f][p] = 2; dip_amt[f][p] = 1;
                end
            run(1, 3, 9);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule